// File: doc/BRIEF.md
# Queued SPI Slave Controller

This block is the receiving end of an SPI link. An external master drives the serial clock and an active-low select. The block works through a queue of fixed-length words. For each queue entry it sends the word stored in a transmit memory and keeps the word it receives in a receive memory, at the same entry index. A working pointer moves through the entries. It stops at a programmed end entry, or it wraps back.

Software fills the transmit memory and writes a small set of control registers: mode, clock polarity, clock phase, word length, queue pointers and wrap behaviour. It then reads the received words and watches the completion flag or the interrupt line. The serial inputs are resynchronised into the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `qspi_slave_queue`

## Requirements
- R1: Words shift only while the run bit is 1, the master bit is 0 and the synchronised select is low. The first entry used after the queue-start pointer is written, or after the run bit rises, is the queue-start pointer.
- R2: Each entry transmits transmit-memory[pointer] MSB first on `miso_o`. The received word is written right-justified, with zeros above it, into receive-memory[pointer].
- R3: With phase 0, data is sampled on the leading serial-clock edge and driven on the trailing edge. With phase 1, data is driven on the leading edge and sampled on the trailing edge. The leading edge is rising when polarity is 0 and falling when polarity is 1.
- R4: The word-length code sets the word size for every entry. Codes 8 to 15 give that many bits. Code 0 and codes 1 to 7 give 16 bits.
- R5: When a full word has shifted, `last_ptr_o` takes the working pointer and the working pointer advances by one.
- R6: If select rises before a full word has shifted, the partial word is dropped. The pointer and `last_ptr_o` stay unchanged, and the next select restarts the same entry from its first bit.
- R7: The working pointer carries over from one select assertion to the next, whether select stays low or toggles between words. Writing the pointer register while select is high redirects the next word to the new queue-start pointer.
- R8: Completing the end entry sets `done_o`. `irq_o` equals `done_o` AND the interrupt enable. Without wrap, the run bit clears and shifting stops.
- R9: With wrap enabled, the entry after the end entry is 0 when the wrap-target bit is 0, and the queue-start pointer when it is 1. The run bit stays set.
- R10: `miso_oe` is 0 whenever select is high or the block is not an enabled slave, and 1 while it is shifting.
- R11: Register map at `reg_addr`:
  - 0: bit0 run, bit1 master, bit2 polarity, bit3 phase, bits7:4 length code.
  - 1: bits3:0 queue-start pointer, bits7:4 end pointer.
  - 2: bit0 wrap enable, bit1 wrap target, bit2 interrupt enable.
  - 3: writing 1 to bit0 clears `done_o`.
- R12: With the master bit set, serial traffic is ignored: no data is driven, nothing is written and `last_ptr_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 2 | Control register select |
| reg_wdata | input | 8 | Control register write data |
| tx_we | input | 1 | Transmit memory write strobe |
| tx_addr | input | 4 | Transmit memory write address |
| tx_wdata | input | 16 | Transmit memory write data |
| rx_addr | input | 4 | Receive memory read address |
| rx_rdata | output | 16 | Receive memory read data, one cycle after the address |
| sclk_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` |
| run_o | output | 1 | Run bit |
| done_o | output | 1 | Queue completion flag |
| irq_o | output | 1 | Interrupt request |
| last_ptr_o | output | 4 | Pointer of the last completed entry |

## Verification
A corrupted working pointer shows up on the next word as a transmit word taken from the wrong entry. The same word also lands at the wrong receive index, and `last_ptr_o` is wrong once that word completes. A bit counter that is off changes the word boundary. That moves the received value by whole bits within one word and shifts every later entry. A wrong edge choice for a clock mode corrupts the first bit the master samples. A fault in the end or wrap logic shows at the first pass over the end entry, through `run_o`, `done_o` and the entry reused next.

// File: rtl/qsq_pkg.sv
package qsq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_QPTR = 2'd1,
    SEL_WRAP = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qsq_sync.sv
module qsq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qsq_ram.sv
module qsq_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qspi_slave_queue.sv
module qspi_slave_queue #(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [2*AW-1:0] reg_wdata,
  input  logic          tx_we,
  input  logic [AW-1:0] tx_addr,
  input  logic [DW-1:0] tx_wdata,
  input  logic [AW-1:0] rx_addr,
  output logic [DW-1:0] rx_rdata,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  output logic          run_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [AW-1:0] last_ptr_o
);
  import qsq_pkg::*;

  localparam int LW = $clog2(DW);
  localparam logic [2:0] SYNC_RST = 3'b010;

  // serial inputs into the system clock domain: {mosi, select, clock}
  logic [2:0] raw_in, syn_in;
  assign raw_in = {mosi_i, ss_n_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    qsq_sync #(.STAGES(SYNC), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(raw_in[g]), .q(syn_in[g])
    );
  end

  logic sclk_s, ss_s, mosi_s, sclk_d;
  assign sclk_s = syn_in[0];
  assign ss_s   = syn_in[1];
  assign mosi_s = syn_in[2];

  // control state
  logic          en_q, mstr_q, cpol_q, cpha_q, wren_q, wrto_q, ie_q, done_q, pend_q;
  logic [LW-1:0] len_q;
  logic [AW-1:0] newq_q, endq_q, wptr_q, cpt_q;
  logic [LW:0]   cnt_q;
  logic [DW-1:0] rsh_q, tx_q;
  logic          miso_q, oe_q;

  logic wr_ctrl, wr_qptr, wr_wrap, wr_stat;
  assign wr_ctrl = reg_we && (reg_addr == SEL_CTRL);
  assign wr_qptr = reg_we && (reg_addr == SEL_QPTR);
  assign wr_wrap = reg_we && (reg_addr == SEL_WRAP);
  assign wr_stat = reg_we && (reg_addr == SEL_STAT);

  // edge selection by mode
  logic rise, fall, lead, trail, samp, drive, active;
  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign lead   = cpol_q ? fall : rise;
  assign trail  = cpol_q ? rise : fall;
  assign samp   = cpha_q ? trail : lead;
  assign drive  = cpha_q ? lead : trail;
  assign active = en_q & ~mstr_q & ~ss_s;

  // word length
  logic [LW:0]   nbits;
  logic [LW-1:0] nm1;
  assign nbits = (len_q < LW'(DW/2)) ? (LW+1)'(DW) : {1'b0, len_q};
  assign nm1   = LW'(nbits - 1'b1);

  logic          last_bit, at_end;
  logic [DW-1:0] rx_word;
  assign last_bit = active && samp && ((cnt_q + 1'b1) == nbits);
  assign at_end   = (wptr_q == endq_q);
  assign rx_word  = {rsh_q[DW-2:0], mosi_s};

  qsq_ram #(.DW(DW), .AW(AW)) u_txram (
    .clk(clk), .we(tx_we), .waddr(tx_addr), .wdata(tx_wdata),
    .raddr(wptr_q), .rdata(tx_q)
  );

  qsq_ram #(.DW(DW), .AW(AW)) u_rxram (
    .clk(clk), .we(last_bit), .waddr(wptr_q), .wdata(rx_word),
    .raddr(rx_addr), .rdata(rx_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; mstr_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      len_q <= '0; newq_q <= '0; endq_q <= '0;
      wren_q <= 1'b0; wrto_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0;
      pend_q <= 1'b0; wptr_q <= '0; cpt_q <= '0; cnt_q <= '0;
      rsh_q <= '0; miso_q <= 1'b0; oe_q <= 1'b0; sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      oe_q   <= active;
      if (wr_ctrl) begin
        en_q   <= reg_wdata[0];
        mstr_q <= reg_wdata[1];
        cpol_q <= reg_wdata[2];
        cpha_q <= reg_wdata[3];
        len_q  <= reg_wdata[4 +: LW];
      end
      if (wr_qptr) begin
        newq_q <= reg_wdata[AW-1:0];
        endq_q <= reg_wdata[2*AW-1:AW];
      end
      if (wr_wrap) begin
        wren_q <= reg_wdata[0];
        wrto_q <= reg_wdata[1];
        ie_q   <= reg_wdata[2];
      end
      if (wr_stat && reg_wdata[0]) done_q <= 1'b0;

      if (!active) begin
        cnt_q  <= '0;
        rsh_q  <= '0;
        miso_q <= tx_q[nm1];
        if (pend_q) begin
          wptr_q <= newq_q;
          pend_q <= 1'b0;
        end
      end else begin
        if (samp) begin
          if (last_bit) begin
            cnt_q <= '0;
            rsh_q <= '0;
            cpt_q <= wptr_q;
            if (at_end) begin
              done_q <= 1'b1;
              if (wren_q) wptr_q <= wrto_q ? newq_q : '0;
              else begin
                en_q   <= 1'b0;
                wptr_q <= wptr_q + 1'b1;
              end
            end else begin
              wptr_q <= wptr_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            rsh_q <= rx_word;
          end
        end
        if (drive) miso_q <= tx_q[nm1 - cnt_q[LW-1:0]];
      end
      // a pointer write or a fresh start re-targets the queue (R7, R1)
      if (wr_qptr || (wr_ctrl && reg_wdata[0] && !en_q)) pend_q <= 1'b1;
    end
  end

  assign miso_o     = miso_q;
  assign miso_oe    = oe_q;
  assign run_o      = en_q;
  assign done_o     = done_q;
  assign irq_o      = done_q & ie_q;
  assign last_ptr_o = cpt_q;

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < nbits));
  p_tristate_r10: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> !miso_oe);
  p_cpt_track_r5: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> (last_ptr_o == $past(wptr_q)));
  p_stop_end_r8: assert property (@(posedge clk) disable iff (rst)
    (last_bit && at_end && !wren_q) |=> (!run_o && done_o));
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (last_bit && at_end && wren_q && !wrto_q) |=> (wptr_q == '0));
  p_hold_ptr_r6: assert property (@(posedge clk) disable iff (rst)
    (!active && !pend_q) |=> (wptr_q == $past(wptr_q)));
endmodule

// File: tb/qspi_slave_queue_test.sv
module qspi_slave_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        tx_we = 1'b0;
  logic [3:0]  tx_addr = '0, rx_addr = '0;
  logic [15:0] tx_wdata = '0, rx_rdata;
  logic        sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
  logic        miso_o, miso_oe, run_o, done_o, irq_o;
  logic [3:0]  last_ptr_o;
  logic        cpol_m = 1'b0, cpha_m = 1'b0, finished = 1'b0;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_slave_queue uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .rx_addr(rx_addr),
    .rx_rdata(rx_rdata), .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .run_o(run_o), .done_o(done_o),
    .irq_o(irq_o), .last_ptr_o(last_ptr_o)
  );

  function automatic logic [15:0] txv(input int i);
    return 16'h5A3C ^ (16'(i) * 16'h0F11);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_rx(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rx_addr = a;
    @(negedge clk); @(negedge clk); d = rx_rdata;
  endtask

  task automatic setup(input logic cp, input logic ph, input logic [3:0] code,
                       input logic [3:0] nq, input logic [3:0] eq,
                       input logic wr, input logic wt, input logic ie);
    wr_reg(2'd3, 8'h01);
    wr_reg(2'd2, {5'b0, ie, wt, wr});
    wr_reg(2'd1, {eq, nq});
    wr_reg(2'd0, {code, ph, cp, 1'b0, 1'b1});
    cpol_m = cp; cpha_m = ph; sclk_i = cp;
    half();
  endtask

  task automatic sel_lo(); ss_n_i = 1'b0; half(); endtask
  task automatic sel_hi(); ss_n_i = 1'b1; half(); half(); endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha_m) begin
        mosi_i = w[i]; half();
        got = {got[14:0], miso_o};
        sclk_i = ~cpol_m; half(); sclk_i = cpol_m;
      end else begin
        sclk_i = ~cpol_m; mosi_i = w[i]; half();
        got = {got[14:0], miso_o};
        sclk_i = cpol_m; half();
      end
    end
    if (!cpha_m) half();
  endtask

  task automatic t_reset();
    check("R11 reset run", {15'b0, run_o}, 16'h0);
    check("R8 reset done", {15'b0, done_o}, 16'h0);
    check("R8 reset irq", {15'b0, irq_o}, 16'h0);
    check("R10 reset oe", {15'b0, miso_oe}, 16'h0);
    check("R5 reset last_ptr", {12'b0, last_ptr_o}, 16'h0);
  endtask

  task automatic t_basic();
    logic [15:0] g, r;
    setup(1'b0, 1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 1'b0, 1'b1);
    sel_lo();
    check("R10 oe while selected", {15'b0, miso_oe}, 16'h1);
    xfer(16'hC3A5, 16, g); check("R2 R3 mode0 word0", g, txv(0));
    xfer(16'h1234, 16, g); check("R7 select held word1", g, txv(1));
    sel_hi();
    check("R10 oe after deselect", {15'b0, miso_oe}, 16'h0);
    check("R5 last_ptr", {12'b0, last_ptr_o}, 16'h1);
    rd_rx(4'd0, r); check("R2 rx entry0", r, 16'hC3A5);
    rd_rx(4'd1, r); check("R2 rx entry1", r, 16'h1234);
  endtask

  task automatic t_partial();
    logic [15:0] g, r;
    sel_lo(); xfer(16'hFFFF, 5, g); sel_hi();
    check("R6 partial bits", g, {11'b0, txv(2)[15:11]});
    check("R6 last_ptr kept", {12'b0, last_ptr_o}, 16'h1);
    sel_lo(); xfer(16'h0F0F, 16, g); sel_hi();
    check("R6 restart same entry", g, txv(2));
    rd_rx(4'd2, r); check("R6 rx entry2 clean", r, 16'h0F0F);
  endtask

  task automatic t_end();
    logic [15:0] g;
    sel_lo(); xfer(16'hAAAA, 16, g); sel_hi();
    check("R8 end word", g, txv(3));
    check("R8 done set", {15'b0, done_o}, 16'h1);
    check("R8 irq raised", {15'b0, irq_o}, 16'h1);
    check("R8 run cleared", {15'b0, run_o}, 16'h0);
    sel_lo();
    check("R1 stopped no oe", {15'b0, miso_oe}, 16'h0);
    xfer(16'h5555, 16, g); sel_hi();
    check("R1 stopped last_ptr", {12'b0, last_ptr_o}, 16'h3);
    wr_reg(2'd3, 8'h01);
    check("R11 done cleared", {15'b0, done_o}, 16'h0);
    check("R11 irq cleared", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_master();
    logic [15:0] g;
    wr_reg(2'd1, 8'h66);
    wr_reg(2'd0, 8'h03);
    sel_lo();
    check("R12 master no oe", {15'b0, miso_oe}, 16'h0);
    xfer(16'h7777, 16, g); sel_hi();
    check("R12 master last_ptr", {12'b0, last_ptr_o}, 16'h3);
  endtask

  task automatic t_wrap_newq();
    logic [15:0] g, r;
    setup(1'b1, 1'b1, 4'd8, 4'd4, 4'd5, 1'b1, 1'b1, 1'b0);
    sel_lo(); xfer(16'h0081, 8, g); sel_hi();
    check("R3 R4 mode3 8-bit entry4", g, {8'b0, txv(4)[7:0]});
    sel_lo(); xfer(16'h007E, 8, g); sel_hi();
    check("R7 toggled entry5", g, {8'b0, txv(5)[7:0]});
    sel_lo(); xfer(16'h00C4, 8, g); sel_hi();
    check("R9 wrap to start", g, {8'b0, txv(4)[7:0]});
    check("R9 run kept", {15'b0, run_o}, 16'h1);
    check("R8 done no irq", {14'b0, done_o, irq_o}, 16'h2);
    rd_rx(4'd4, r); check("R2 R4 rx entry4 right-justified", r, 16'h00C4);
    rd_rx(4'd5, r); check("R2 rx entry5", r, 16'h007E);
  endtask

  task automatic t_wrap_zero();
    logic [15:0] g, r;
    setup(1'b1, 1'b0, 4'd12, 4'd14, 4'd15, 1'b1, 1'b0, 1'b1);
    sel_lo();
    xfer(16'h0ABC, 12, g); check("R3 R4 mode2 12-bit entry14", g, txv(14) & 16'h0FFF);
    xfer(16'h0123, 12, g); check("R4 entry15", g, txv(15) & 16'h0FFF);
    xfer(16'h0F0F, 12, g); check("R9 wrap to zero", g, txv(0) & 16'h0FFF);
    sel_hi();
    check("R9 last_ptr zero", {12'b0, last_ptr_o}, 16'h0);
    check("R8 irq with enable", {15'b0, irq_o}, 16'h1);
    rd_rx(4'd15, r); check("R2 rx entry15", r, 16'h0123);
    rd_rx(4'd0, r);  check("R2 rx entry0 rewritten", r, 16'h0F0F);
  endtask

  task automatic t_len_low();
    logic [15:0] g, r;
    setup(1'b0, 1'b1, 4'd3, 4'd7, 4'd7, 1'b0, 1'b0, 1'b0);
    sel_lo(); xfer(16'hBEEF, 16, g); sel_hi();
    check("R4 R3 code3 is 16 bits mode1", g, txv(7));
    rd_rx(4'd7, r); check("R4 rx entry7", r, 16'hBEEF);
    check("R8 stop no wrap", {15'b0, run_o}, 16'h0);
  endtask

  task automatic t_retarget();
    logic [15:0] g;
    setup(1'b0, 1'b0, 4'd0, 4'd8, 4'd10, 1'b0, 1'b0, 1'b0);
    sel_lo(); xfer(16'h1111, 16, g); sel_hi();
    check("R1 start at queue-start", g, txv(8));
    sel_lo(); xfer(16'h2222, 16, g); sel_hi();
    check("R7 pointer carried", g, txv(9));
    wr_reg(2'd1, 8'hCC);
    sel_lo(); xfer(16'h3333, 16, g); sel_hi();
    check("R7 redirected", g, txv(12));
    check("R5 last_ptr redirected", {12'b0, last_ptr_o}, 16'hC);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tx_we = 1'b1; tx_addr = 4'(i); tx_wdata = txv(i);
    end
    @(negedge clk); tx_we = 1'b0;
    t_reset();
    t_basic();
    t_partial();
    t_end();
    t_master();
    t_wrap_newq();
    t_wrap_zero();
    t_len_low();
    t_retarget();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule